// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Network

This block sits in front of the ALU in the execute stage of a five-stage in-order pipeline. For each of the two ALU operands it decides where the value should come from. The first choice is the register-file value captured when the instruction left decode. The second is the result sitting in the EX/MEM pipeline register. The third is the value being written back from MEM/WB. It then drives the chosen value to the ALU. A dependent instruction that directly follows its producer therefore reads the fresh result without a stall. The cost is one multiplexer level on the execute-stage timing path.

The block is purely combinational. Its inputs are the two source register numbers of the instruction in execute, plus the destination register number and register-write flag of the instructions in the memory and writeback stages. It also takes the four candidate data values and a flag that marks the writeback instruction as a load. When both older instructions target the register being read, the younger one (in EX/MEM) wins. Register 0 is hard-wired to zero and is never bypassed.

Top module: `bypass_net`

## Requirements
- R1: Each select output uses the code 2'b00 for the register-file value, 2'b01 for the writeback value and 2'b10 for the EX/MEM result; the code 2'b11 never appears.
- R2: When the EX/MEM write flag is high, its destination equals a nonzero source register, the select for that operand is 2'b10 and the operand equals the EX/MEM ALU result.
- R3: When EX/MEM does not match a nonzero source but the MEM/WB write flag is high and its destination equals that source, the select is 2'b01 and the operand equals the writeback value.
- R4: When both EX/MEM and MEM/WB match the same nonzero source, the EX/MEM result is selected (2'b10).
- R5: A stage whose write flag is low never causes a bypass, even if its destination equals the source register.
- R6: A source register number of 0 always selects the register-file value (2'b00), whatever the producers' destinations and write flags.
- R7: The writeback value is the memory load data when the writeback instruction is a load, and its ALU result otherwise.
- R8: With no qualifying producer, the select is 2'b00 and the operand equals the register-file value latched in ID/EX.
- R9: The two operands are resolved independently, so each may pick a different source in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| exSrcRegA | input | REG_W | First source register number of the instruction in execute |
| exSrcRegB | input | REG_W | Second source register number of the instruction in execute |
| rfOperA | input | DATA_W | Register-file value for operand A, latched in ID/EX |
| rfOperB | input | DATA_W | Register-file value for operand B, latched in ID/EX |
| memDstReg | input | REG_W | Destination register of the instruction in EX/MEM |
| memWrEn | input | 1 | Register-write flag of the instruction in EX/MEM |
| memAluRes | input | DATA_W | ALU result held in EX/MEM |
| wbDstReg | input | REG_W | Destination register of the instruction in MEM/WB |
| wbWrEn | input | 1 | Register-write flag of the instruction in MEM/WB |
| wbIsLoad | input | 1 | High when the MEM/WB instruction is a load |
| wbAluRes | input | DATA_W | ALU result held in MEM/WB |
| wbLoadData | input | DATA_W | Memory read data held in MEM/WB |
| selA | output | 2 | Source select code for operand A |
| selB | output | 2 | Source select code for operand B |
| operA | output | DATA_W | Operand A driven to the ALU |
| operB | output | DATA_W | Operand B driven to the ALU |

## Verification
The bound checks run whenever an input changes. They confirm that no illegal select code appears and that a zero source never bypasses. They also confirm that a qualifying EX/MEM match always wins and that a lone MEM/WB match picks the writeback value. Finally, they confirm that each operand equals the data source its select names, including the load-versus-ALU choice on the writeback path. Only the bench's sweep shows that the full decision is right for every combination of source, destinations, write flags and load flag. That sweep covers register 0 and the cases where a destination matches but its write flag is low. It also covers pairs of operands that resolve to different sources at once.

// File: rtl/bypass_pkg.sv
package bypass_pkg;

  // Operand source select; the encoding is visible on the block's ports.
  typedef enum logic [1:0] {
    SRC_REGFILE   = 2'b00,
    SRC_WRITEBACK = 2'b01,
    SRC_EXMEM     = 2'b10
  } fwdSrc_e;

  // Strobes from the control half to the datapath half.
  typedef struct packed {
    fwdSrc_e selA;
    fwdSrc_e selB;
  } fwdStrobe_t;

endpackage

// File: rtl/bypass_match.sv
// Per-operand producer comparison and priority pick.
module bypass_match
  import bypass_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] srcReg,
  input  logic [REG_W-1:0] memDstReg,
  input  logic             memWrEn,
  input  logic [REG_W-1:0] wbDstReg,
  input  logic             wbWrEn,
  output fwdSrc_e          sel
);

  logic srcLive;
  logic memHit;
  logic wbHit;

  // Register 0 reads as zero, so it never takes a bypassed value.
  assign srcLive = |srcReg;
  assign memHit  = srcLive && memWrEn && (memDstReg == srcReg);
  assign wbHit   = srcLive && wbWrEn  && (wbDstReg  == srcReg);

  // The younger producer (EX/MEM) has priority over MEM/WB.
  always_comb begin
    if (memHit)     sel = SRC_EXMEM;
    else if (wbHit) sel = SRC_WRITEBACK;
    else            sel = SRC_REGFILE;
  end

endmodule

// File: rtl/bypass_ctrl.sv
// Control half: one match unit per operand, packed into the strobe struct.
module bypass_ctrl
  import bypass_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] srcRegA,
  input  logic [REG_W-1:0] srcRegB,
  input  logic [REG_W-1:0] memDstReg,
  input  logic             memWrEn,
  input  logic [REG_W-1:0] wbDstReg,
  input  logic             wbWrEn,
  output fwdStrobe_t       strobe
);

  localparam int N_OPER = 2;

  logic [N_OPER-1:0][REG_W-1:0] srcVec;
  fwdSrc_e                      selVec [N_OPER];

  assign srcVec[0] = srcRegA;
  assign srcVec[1] = srcRegB;

  for (genvar g = 0; g < N_OPER; g++) begin : g_oper
    bypass_match #(.REG_W(REG_W)) u_match (
      .srcReg    (srcVec[g]),
      .memDstReg (memDstReg),
      .memWrEn   (memWrEn),
      .wbDstReg  (wbDstReg),
      .wbWrEn    (wbWrEn),
      .sel       (selVec[g])
    );
  end

  assign strobe.selA = selVec[0];
  assign strobe.selB = selVec[1];

endmodule

// File: rtl/bypass_dpath.sv
// Datapath half: writeback value choice and the two operand multiplexers.
module bypass_dpath
  import bypass_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  fwdStrobe_t        strobe,
  input  logic [DATA_W-1:0] rfOperA,
  input  logic [DATA_W-1:0] rfOperB,
  input  logic [DATA_W-1:0] memAluRes,
  input  logic              wbIsLoad,
  input  logic [DATA_W-1:0] wbAluRes,
  input  logic [DATA_W-1:0] wbLoadData,
  output logic [DATA_W-1:0] operA,
  output logic [DATA_W-1:0] operB
);

  localparam int N_OPER = 2;

  logic [DATA_W-1:0]             wbValue;
  logic [N_OPER-1:0][DATA_W-1:0] rfVec;
  logic [N_OPER-1:0][DATA_W-1:0] outVec;
  fwdSrc_e                       selVec [N_OPER];

  // A load delivers memory data; anything else delivers its ALU result.
  assign wbValue   = wbIsLoad ? wbLoadData : wbAluRes;

  assign rfVec[0]  = rfOperA;
  assign rfVec[1]  = rfOperB;
  assign selVec[0] = strobe.selA;
  assign selVec[1] = strobe.selB;

  for (genvar g = 0; g < N_OPER; g++) begin : g_mux
    always_comb begin
      unique case (selVec[g])
        SRC_EXMEM:     outVec[g] = memAluRes;
        SRC_WRITEBACK: outVec[g] = wbValue;
        default:       outVec[g] = rfVec[g];
      endcase
    end
  end

  assign operA = outVec[0];
  assign operB = outVec[1];

endmodule

// File: rtl/bypass_net.sv
// Thin top: control and datapath halves joined by the strobe struct.
module bypass_net
  import bypass_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_W  = 5
) (
  input  logic [REG_W-1:0]  exSrcRegA,
  input  logic [REG_W-1:0]  exSrcRegB,
  input  logic [DATA_W-1:0] rfOperA,
  input  logic [DATA_W-1:0] rfOperB,
  input  logic [REG_W-1:0]  memDstReg,
  input  logic              memWrEn,
  input  logic [DATA_W-1:0] memAluRes,
  input  logic [REG_W-1:0]  wbDstReg,
  input  logic              wbWrEn,
  input  logic              wbIsLoad,
  input  logic [DATA_W-1:0] wbAluRes,
  input  logic [DATA_W-1:0] wbLoadData,
  output logic [1:0]        selA,
  output logic [1:0]        selB,
  output logic [DATA_W-1:0] operA,
  output logic [DATA_W-1:0] operB
);

  fwdStrobe_t strobe;

  bypass_ctrl #(.REG_W(REG_W)) u_ctrl (
    .srcRegA   (exSrcRegA),
    .srcRegB   (exSrcRegB),
    .memDstReg (memDstReg),
    .memWrEn   (memWrEn),
    .wbDstReg  (wbDstReg),
    .wbWrEn    (wbWrEn),
    .strobe    (strobe)
  );

  bypass_dpath #(.DATA_W(DATA_W)) u_dpath (
    .strobe     (strobe),
    .rfOperA    (rfOperA),
    .rfOperB    (rfOperB),
    .memAluRes  (memAluRes),
    .wbIsLoad   (wbIsLoad),
    .wbAluRes   (wbAluRes),
    .wbLoadData (wbLoadData),
    .operA      (operA),
    .operB      (operB)
  );

  assign selA = strobe.selA;
  assign selB = strobe.selB;

endmodule

// File: rtl/bypass_oper_chk.sv
// Per-operand checker, bound twice to the top (once per operand).
module bypass_oper_chk #(
  parameter int DATA_W = 32,
  parameter int REG_W  = 5
) (
  input logic [REG_W-1:0]  srcReg,
  input logic [DATA_W-1:0] rfOper,
  input logic [REG_W-1:0]  memDstReg,
  input logic              memWrEn,
  input logic [DATA_W-1:0] memAluRes,
  input logic [REG_W-1:0]  wbDstReg,
  input logic              wbWrEn,
  input logic              wbIsLoad,
  input logic [DATA_W-1:0] wbAluRes,
  input logic [DATA_W-1:0] wbLoadData,
  input logic [1:0]        sel,
  input logic [DATA_W-1:0] oper
);

  logic known;
  logic memQual;
  logic wbQual;

  assign known   = !$isunknown({srcReg, memDstReg, memWrEn, wbDstReg, wbWrEn, wbIsLoad, sel});
  assign memQual = memWrEn && (memDstReg == srcReg) && (srcReg != '0);
  assign wbQual  = wbWrEn  && (wbDstReg  == srcReg) && (srcReg != '0);

  always_comb begin
    if (known) begin
      AST_SEL_LEGAL: assert (sel != 2'b11) else $error("illegal select code"); // R1
      AST_ZERO_SRC: assert (!(srcReg == '0) || sel == 2'b00) else $error("register 0 bypassed"); // R6
      AST_EXMEM_WINS: assert (!memQual || sel == 2'b10) else $error("EX/MEM match not chosen"); // R4
      AST_WB_PICK: assert (!(!memQual && wbQual) || sel == 2'b01) else $error("MEM/WB match not chosen"); // R3
      AST_NO_PRODUCER: assert (memQual || wbQual || sel == 2'b00) else $error("bypass without qualified producer"); // R5
      AST_OPER_EXMEM: assert (sel != 2'b10 || oper == memAluRes) else $error("operand not EX/MEM result"); // R2
      AST_OPER_WB: assert (sel != 2'b01 || oper == (wbIsLoad ? wbLoadData : wbAluRes)) else $error("operand not writeback value"); // R7
      AST_OPER_RF: assert (sel != 2'b00 || oper == rfOper) else $error("operand not register-file value"); // R8
    end
  end

endmodule

bind bypass_net bypass_oper_chk #(.DATA_W(DATA_W), .REG_W(REG_W)) u_chkA (
  .srcReg(exSrcRegA), .rfOper(rfOperA), .memDstReg(memDstReg), .memWrEn(memWrEn),
  .memAluRes(memAluRes), .wbDstReg(wbDstReg), .wbWrEn(wbWrEn), .wbIsLoad(wbIsLoad),
  .wbAluRes(wbAluRes), .wbLoadData(wbLoadData), .sel(selA), .oper(operA)
);

bind bypass_net bypass_oper_chk #(.DATA_W(DATA_W), .REG_W(REG_W)) u_chkB (
  .srcReg(exSrcRegB), .rfOper(rfOperB), .memDstReg(memDstReg), .memWrEn(memWrEn),
  .memAluRes(memAluRes), .wbDstReg(wbDstReg), .wbWrEn(wbWrEn), .wbIsLoad(wbIsLoad),
  .wbAluRes(wbAluRes), .wbLoadData(wbLoadData), .sel(selB), .oper(operB)
);

// File: tb/test_bypass_net.sv
module test_bypass_net;

  localparam int DATA_W = 32;
  localparam int REG_W  = 3;
  localparam int NREG   = 1 << REG_W;

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic [REG_W-1:0]  exSrcRegA, exSrcRegB, memDstReg, wbDstReg;
  logic              memWrEn, wbWrEn, wbIsLoad;
  logic [DATA_W-1:0] rfOperA, rfOperB, memAluRes, wbAluRes, wbLoadData;
  logic [1:0]        selA, selB;
  logic [DATA_W-1:0] operA, operB;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  bypass_net #(.DATA_W(DATA_W), .REG_W(REG_W)) i_bypass_net (
    .exSrcRegA(exSrcRegA), .exSrcRegB(exSrcRegB),
    .rfOperA(rfOperA), .rfOperB(rfOperB),
    .memDstReg(memDstReg), .memWrEn(memWrEn), .memAluRes(memAluRes),
    .wbDstReg(wbDstReg), .wbWrEn(wbWrEn), .wbIsLoad(wbIsLoad),
    .wbAluRes(wbAluRes), .wbLoadData(wbLoadData),
    .selA(selA), .selB(selB), .operA(operA), .operB(operB)
  );

  task automatic check(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (srcA=%0d srcB=%0d mem=%0d/%0b wb=%0d/%0b ld=%0b)",
               tag, act, exp, exSrcRegA, exSrcRegB, memDstReg, memWrEn, wbDstReg, wbWrEn, wbIsLoad);
    end
  endtask

  // Reference select from the requirements.
  function automatic logic [1:0] refSel(input logic [REG_W-1:0] src);
    if (src == 0) return 2'b00;                                  // R6
    if (memWrEn && memDstReg == src) return 2'b10;               // R2, R4
    if (wbWrEn && wbDstReg == src) return 2'b01;                 // R3
    return 2'b00;                                                // R5, R8
  endfunction

  function automatic string refTag(input logic [REG_W-1:0] src);
    if (src == 0) return "R6";
    if (memWrEn && memDstReg == src) return (wbWrEn && wbDstReg == src) ? "R4" : "R2";
    if (wbWrEn && wbDstReg == src) return "R3";
    if (memDstReg == src || wbDstReg == src) return "R5";
    return "R8";
  endfunction

  function automatic logic [DATA_W-1:0] refOper(input logic [1:0] s, input logic [DATA_W-1:0] rf);
    case (s)
      2'b10:   return memAluRes;
      2'b01:   return wbIsLoad ? wbLoadData : wbAluRes;          // R7
      default: return rf;
    endcase
  endfunction

  task automatic checkVector();
    logic [1:0] eA, eB;
    string tA, tB;
    eA = refSel(exSrcRegA);
    eB = refSel(exSrcRegB);
    tA = refTag(exSrcRegA);
    tB = refTag(exSrcRegB);
    check("R1", {30'd0, selA == 2'b11 || selB == 2'b11}, '0);
    check(tA, {30'd0, selA}, {30'd0, eA});
    check(tB, {30'd0, selB}, {30'd0, eB});
    check(eA == 2'b01 ? "R7" : tA, operA, refOper(eA, rfOperA));
    check(eB == 2'b01 ? "R7" : tB, operB, refOper(eB, rfOperB));
    if (eA != eB)
      check("R9", {30'd0, selA, selB} ^ {30'd0, eA, eB}, '0);
  endtask

  initial begin
    // Quiet state: all zero inputs, both operands from the register file (R8).
    exSrcRegA = '0; exSrcRegB = '0; memDstReg = '0; wbDstReg = '0;
    memWrEn = 1'b0; wbWrEn = 1'b0; wbIsLoad = 1'b0;
    rfOperA = 32'h1111_1111; rfOperB = 32'h2222_2222;
    memAluRes = 32'h3333_3333; wbAluRes = 32'h4444_4444; wbLoadData = 32'h5555_5555;
    @(negedge clk);
    check("R8", {30'd0, selA}, '0);
    check("R8", operA, 32'h1111_1111);
    check("R8", operB, 32'h2222_2222);

    // Exhaustive sweep of the small configuration.
    for (int a = 0; a < NREG; a++)
      for (int b = 0; b < NREG; b++)
        for (int md = 0; md < NREG; md++)
          for (int mw = 0; mw < 2; mw++)
            for (int wd = 0; wd < NREG; wd++)
              for (int ww = 0; ww < 2; ww++)
                for (int ld = 0; ld < 2; ld++) begin
                  @(posedge clk);
                  exSrcRegA  = REG_W'(a);
                  exSrcRegB  = REG_W'(b);
                  memDstReg  = REG_W'(md);
                  memWrEn    = mw[0];
                  wbDstReg   = REG_W'(wd);
                  wbWrEn     = ww[0];
                  wbIsLoad   = ld[0];
                  rfOperA    = {16'hA0A0, 16'(a * 512 + md * 16 + wd)};
                  rfOperB    = {16'hB0B0, 16'(b * 512 + md * 16 + wd)};
                  memAluRes  = {16'hC0C0, 16'(md * 64 + a + b)};
                  wbAluRes   = {16'hD0D0, 16'(wd * 64 + a + b)};
                  wbLoadData = {16'hE0E0, 16'(wd * 64 + a + b)};
                  @(negedge clk);
                  checkVector();
                end

    if (!done) begin
      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule